// File: doc/BRIEF.md
# Serial Line Bit-Rate Detector

This block listens to the raw receive line of an asynchronous serial port. It works out the sender's bit rate from the first framing character of each packet, and it produces the reload value for a baud generator that oversamples each bit 16 times. The character is 0Fh in an 8-data-bit, no-parity, one-stop-bit frame, sent LSB first. On the line it looks like this: a low start bit, four high data bits, four low data bits, then a high stop bit.

The detector times the span from the leading falling edge of that character to the falling edge that ends its four high bits. That span is five bit times. From it the detector computes the value X for which the clock equals (X + 1) × 16 × baud. It then loads X into its divisor output and pulses a strobe for one cycle.

The packet receiver supplies a busy flag. A start character that arrives while a packet is in progress never restarts the measurement, so the rate is re-learned once at the head of each new packet.

Top module: `baud_sync_detect`

## Requirements
- R1: During and right after reset, `divisor` equals `DIV_INIT` (0 by default) and `locked` is low.
- R2: A measurement opens when the line falls while the detector is idle and `pkt_busy` is low. It closes at the first falling edge after the line has gone high again. With M the number of clock cycles between the two edges, the loaded value is floor((M + 40) / 80) − 1, which is M / 80 rounded to nearest, minus one.
- R3: If floor((M + 40) / 80) is 0, the loaded value is clamped to 0 instead of going negative.
- R4: If the computed value exceeds 2^DIV_W − 1, the loaded value is 2^DIV_W − 1.
- R5: `locked` is high for exactly one cycle per completed measurement, in the cycle where the new `divisor` first appears. `divisor` never changes without it.
- R6: While the detector is idle and `pkt_busy` is high, falling edges on the line start no measurement: no strobe, and `divisor` is kept.
- R7: A measurement that runs 2^CNT_W − 1 cycles without closing is dropped. There is no strobe and the old `divisor` is kept.
- R8: After a completed measurement, the line is ignored until one of two things happens: `pkt_busy` has been seen high and then low again, or 2^CNT_W − 1 cycles pass without `pkt_busy` rising. Only then can a new measurement start.
- R9: Each new packet causes a fresh measurement, and its result replaces the previous divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Raw serial receive line, idle high |
| pkt_busy | input | 1 | High while the packet receiver is inside a packet |
| divisor | output | DIV_W | Reload value for the 16x baud generator |
| locked | output | 1 | One-cycle pulse when a new divisor is loaded |

## Verification
The embedded properties watch on every cycle for the following:
- the strobe lasting longer than one cycle;
- the divisor moving without the strobe;
- a measurement starting while the receiver is busy;
- an overflowing count producing a load.

The arithmetic can only be shown by the bench's scenarios, which compare the loaded values against an independent model. These cover exact and rounded bit periods and the clamping at both ends. The bench scenarios also show the lockout after a lock and the timeout that re-arms the detector.

// File: rtl/baud_sync_detect.sv
module baud_sync_detect #(
  parameter int DIV_W     = 8,
  parameter int CNT_W     = 16,
  parameter int OVS       = 16,
  parameter int SYNC_BITS = 5,
  parameter logic [DIV_W-1:0] DIV_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic             pkt_busy,
  output logic [DIV_W-1:0] divisor,
  output logic             locked
);

  localparam int DEN = OVS * SYNC_BITS;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W:0]   DEN_W   = (CNT_W+1)'(DEN);
  localparam logic [CNT_W:0]   HALF_W  = (CNT_W+1)'(DEN / 2);
  localparam logic [CNT_W:0]   DIV_TOP = (CNT_W+1)'((1 << DIV_W) - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_HIGH, S_SETTLE, S_BUSY} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             rx_s1, rx_s2, rx_d;
  logic [CNT_W:0]   meas, quo, xval;
  logic [DIV_W-1:0] new_div;

  wire fall = rx_d & ~rx_s2;
  wire rise = ~rx_d & rx_s2;

  assign meas = {1'b0, cnt} + 1'b1;
  assign quo  = (meas + HALF_W) / DEN_W;
  assign xval = quo - 1'b1;

  always_comb begin
    if (quo == '0)          new_div = '0;
    else if (xval > DIV_TOP) new_div = '1;
    else                    new_div = xval[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1   <= 1'b1;
      rx_s2   <= 1'b1;
      rx_d    <= 1'b1;
      state   <= S_IDLE;
      cnt     <= '0;
      divisor <= DIV_INIT;
      locked  <= 1'b0;
    end else begin
      rx_s1  <= rxd;
      rx_s2  <= rx_s1;
      rx_d   <= rx_s2;
      locked <= 1'b0;
      case (state)
        S_IDLE:
          if (fall && !pkt_busy) begin
            state <= S_START;
            cnt   <= '0;
          end
        S_START:
          if (cnt == CNT_MAX) state <= S_IDLE;
          else begin
            cnt <= cnt + 1'b1;
            if (rise) state <= S_HIGH;
          end
        S_HIGH:
          if (cnt == CNT_MAX) state <= S_IDLE;
          else if (fall) begin
            divisor <= new_div;
            locked  <= 1'b1;
            state   <= S_SETTLE;
            cnt     <= '0;
          end else cnt <= cnt + 1'b1;
        S_SETTLE:
          if (pkt_busy) state <= S_BUSY;
          else if (cnt == CNT_MAX) state <= S_IDLE;
          else cnt <= cnt + 1'b1;
        S_BUSY:
          if (!pkt_busy) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> !locked);

  p_div_moves_with_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(divisor) |-> locked);

  p_strobe_enters_lockout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> state == S_SETTLE);

  p_busy_holds_lockout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUSY && pkt_busy) |=> state == S_BUSY);

  p_no_start_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && pkt_busy) |=> state == S_IDLE);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_START || state == S_HIGH) && cnt == CNT_MAX) |=> (state == S_IDLE && !locked));

endmodule

// File: tb/baud_sync_detect_test.sv
module baud_sync_detect_test;
  localparam int DIV_W = 4;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic pkt_busy = 1'b0;
  logic [DIV_W-1:0] divisor;
  logic locked;

  int errors = 0;
  int checks = 0;
  int lock_cnt = 0;
  logic locked_q = 1'b0;
  logic [DIV_W-1:0] cur;

  always #2 clk = ~clk;

  baud_sync_detect #(.DIV_W(DIV_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .pkt_busy(pkt_busy),
    .divisor(divisor), .locked(locked));

  always @(posedge clk) begin
    locked_q <= locked;
    if (locked) lock_cnt <= lock_cnt + 1;
    if (rst_n && locked && locked_q) begin
      errors++;
      $display("FAIL R5 strobe wider than one cycle: actual=2+ expected=1");
    end
  end

  function automatic logic [DIV_W-1:0] exp_div(int p);
    int m = 5 * p;
    int q = (m + 40) / 80;
    if (q == 0) return '0;
    if (q - 1 > (1 << DIV_W) - 1) return '1;
    return DIV_W'(q - 1);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_char(int p, logic [7:0] b);
    @(negedge clk); rxd = 1'b0;
    idle(p - 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rxd = b[i];
      idle(p - 1);
    end
    @(negedge clk); rxd = 1'b1;
    idle(p - 1);
  endtask

  task automatic do_packet(string req, int p, int p2);
    int base;
    base = lock_cnt;
    fork
      send_char(p, 8'h0F);
      begin
        wait (lock_cnt != base);
        @(negedge clk);
        pkt_busy = 1'b1;
      end
    join
    check({req, " R5 one strobe"}, lock_cnt - base, 1);
    check({req, " divisor"}, divisor, exp_div(p));
    send_char(p2, 8'h0F);
    send_char(p2, 8'h55);
    idle(5);
    pkt_busy = 1'b0;
    idle(5);
    check("R8 busy packet ignored: divisor", divisor, exp_div(p));
    check("R8 busy packet ignored: strobes", lock_cnt - base, 1);
    cur = exp_div(p);
  endtask

  initial begin
    repeat (20 * 190000) #1;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int base;
    int p;
    void'($urandom(32'd4217));
    idle(3);
    check("R1 reset divisor", divisor, 0);
    check("R1 reset locked", locked, 0);
    rst_n = 1'b1;
    idle(5);
    check("R1 after reset divisor", divisor, 0);

    do_packet("R2 exact 16", 16 * 6, 40);
    do_packet("R2 round down", 23, 60);
    do_packet("R2 round up", 24, 60);
    do_packet("R2 mid", 160, 30);
    do_packet("R3 clamp low", 4, 50);
    do_packet("R2 back up", 16 * 9, 20);
    do_packet("R4 saturate", 700, 20);

    for (int k = 0; k < 8; k++) begin
      p = 16 + int'($urandom % 285);
      do_packet("R9 random packet", p, 16 + int'($urandom % 100));
    end

    base = lock_cnt;
    pkt_busy = 1'b1;
    idle(3);
    send_char(50, 8'h0F);
    idle(10);
    pkt_busy = 1'b0;
    idle(5);
    check("R6 busy idle strobes", lock_cnt - base, 0);
    check("R6 busy idle divisor", divisor, cur);

    base = lock_cnt;
    send_char(900, 8'h0F);
    idle(4500);
    check("R7 overflow strobes", lock_cnt - base, 0);
    check("R7 overflow divisor", divisor, cur);

    base = lock_cnt;
    send_char(48, 8'h0F);
    check("R8 lock before timeout test", divisor, exp_div(48));
    cur = exp_div(48);
    send_char(112, 8'h0F);
    check("R8 no relock inside lockout", lock_cnt - base, 1);
    check("R8 divisor held inside lockout", divisor, cur);
    idle(4200);
    send_char(208, 8'h0F);
    check("R8 rearm after timeout strobes", lock_cnt - base, 2);
    check("R8 rearm after timeout divisor", divisor, exp_div(208));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule